// File: doc/BRIEF.md
# USB 2.0 host operational command and status registers

This block holds the run-time command, status and interrupt-enable registers of a USB 2.0 host controller. Software reaches them through a plain word-addressed write strobe and a combinational read port. The block drives the enables for the asynchronous and periodic schedule engines. It runs a doorbell handshake with the cache-eviction logic, and it raises a paced interrupt line.

The schedule engines and the eviction logic are outside the block. The block sees them only as a request output, a completion pulse and two enable outputs.

A write that sets the controller-reset bit starts a timed internal reset. For a fixed number of cycles the reset holds every operational register at its default and ignores all writes, including one that tries to clear the bit. The interrupt line follows a threshold counter that counts microframe strobes. The interrupt is raised only on a counter boundary.

Top module: `usbh_opreg_top`

## Requirements
- R1: After `rst_ni` is released, the command word (byte offset 0x0) reads 0x0003_0000, which is threshold code 3 in bits 18:16. The status word (offset 0x4) and the interrupt-enable word (offset 0x8) read 0. `irq_o`, `evict_req_o`, `hc_reset_o`, `async_en_o` and `periodic_en_o` are all low.
- R2: Command bit 5 (async schedule enable) and command bit 4 (periodic schedule enable) can be written and read back. They drive `async_en_o` and `periodic_en_o`.
- R3: Command bits 3:2 (frame-list size, 00 = 1024 entries) always read 00, whatever value is written to them.
- R4: A command write with bit 6 (doorbell) and bit 5 both at 1 sets the doorbell. The doorbell reads back as 1 on bit 6 and drives `evict_req_o`. A later write of 0 to bit 6 leaves it set.
- R5: A command write with bit 6 = 1 and bit 5 = 0 leaves the doorbell at 0.
- R6: An `evict_done_i` pulse while the doorbell is set does two things one cycle later: it clears the doorbell and sets status bit 5 (async-advance). A pulse while the doorbell is clear changes nothing.
- R7: Status bit 5 is write-1-to-clear at offset 0x4, and writing 0 to it has no effect. If a set event and a clearing write come in the same cycle, the set wins.
- R8: The 3-bit code in command bits 18:16 selects a threshold of 2^code microframes, and codes 6 and 7 both select 64. A threshold boundary is every threshold-th `uframe_i` strobe, counted from the last boundary or from reset.
- R9: `irq_o` rises only in the cycle after a boundary strobe, and only when status bit 5 and interrupt-enable bit 5 (offset 0x8) are both 1.
- R10: `irq_o` falls one cycle after status bit 5 or interrupt-enable bit 5 becomes 0.
- R11: Writing 1 to command bit 1 starts a controller reset that lasts exactly RST_CYCLES cycles. During it, command bit 1 and status bit 12 (halted) read 1 and `hc_reset_o` is high. All outputs and all other fields sit at their defaults, and every write is ignored, including a write of 0 to bit 1.
- R12: When the reset ends, bit 1 reads 0, all operational registers are back at their R1 values, and the threshold counter restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte offset of the register accessed |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| uframe_i | input | 1 | One-cycle strobe per microframe |
| evict_done_i | input | 1 | Eviction logic reports cached schedule state flushed |
| evict_req_o | output | 1 | Doorbell pending, request to the eviction logic |
| async_en_o | output | 1 | Asynchronous schedule enable |
| periodic_en_o | output | 1 | Periodic schedule enable |
| hc_reset_o | output | 1 | Controller reset in progress, aborts engine activity |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with RST_CYCLES set to 6. This keeps the whole reset window short enough to count cycle by cycle, and still leaves room to issue a cancelling write and an ignored interrupt-enable write inside it. The threshold counter keeps its default width. This puts the shortest useful period (code 2), the default (code 3) and the saturating code 7 (64 strobes) within a few hundred cycles. It also lets a part-filled counter be left behind by a reset, so that R12 can catch a counter that is not restarted.

// File: rtl/usbh_opreg_pkg.sv
package usbh_opreg_pkg;
  localparam int unsigned OFS_CMD = 0;
  localparam int unsigned OFS_STS = 4;
  localparam int unsigned OFS_IE  = 8;

  localparam int unsigned CMD_HCRST   = 1;
  localparam int unsigned CMD_FLS_LO  = 2;
  localparam int unsigned CMD_PER_EN  = 4;
  localparam int unsigned CMD_ASY_EN  = 5;
  localparam int unsigned CMD_DBELL   = 6;
  localparam int unsigned CMD_THR_LO  = 16;

  localparam int unsigned STS_AADV    = 5;
  localparam int unsigned STS_HALT    = 12;
  localparam int unsigned IE_AADV     = 5;

  localparam int unsigned THR_W       = 3;
  localparam logic [THR_W-1:0] THR_DEF = 3'd3;

  typedef struct packed {
    logic [THR_W-1:0] thr;
    logic             dbell;
    logic             asy_en;
    logic             per_en;
  } cmd_t;

  localparam cmd_t CMD_DEF = '{thr: THR_DEF, dbell: 1'b0, asy_en: 1'b0, per_en: 1'b0};
endpackage

// File: rtl/usbh_hcrst_seq.sv
module usbh_hcrst_seq #(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic clr_o
);
  localparam int unsigned CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  // clear covers the start edge as well as the whole window
  assign clr_o  = start_i | busy_q;
endmodule

// File: rtl/usbh_opreg_regs.sv
module usbh_opreg_regs
  import usbh_opreg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_cmd_i,
  input  logic             wr_sts_i,
  input  logic             wr_ie_i,
  input  logic             w_per_i,
  input  logic             w_asy_i,
  input  logic             w_dbell_i,
  input  logic [THR_W-1:0] w_thr_i,
  input  logic             w_aadv_i,
  input  logic             evict_done_i,
  output cmd_t             cmd_o,
  output logic             sts_aadv_o,
  output logic             ie_aadv_o
);
  cmd_t cmd_q;
  logic sts_q, ie_q, aadv_set;

  assign aadv_set = cmd_q.dbell & evict_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= CMD_DEF;
      sts_q <= 1'b0;
      ie_q  <= 1'b0;
    end else if (clr_i) begin
      cmd_q <= CMD_DEF;
      sts_q <= 1'b0;
      ie_q  <= 1'b0;
    end else begin
      if (wr_cmd_i) begin
        cmd_q.per_en <= w_per_i;
        cmd_q.asy_en <= w_asy_i;
        cmd_q.thr    <= w_thr_i;
      end
      // only the eviction handshake may lower the doorbell
      if (aadv_set)
        cmd_q.dbell <= 1'b0;
      else if (wr_cmd_i && w_dbell_i && w_asy_i)
        cmd_q.dbell <= 1'b1;

      if (aadv_set)
        sts_q <= 1'b1;
      else if (wr_sts_i && w_aadv_i)
        sts_q <= 1'b0;

      if (wr_ie_i)
        ie_q <= w_aadv_i;
    end
  end

  assign cmd_o      = cmd_q;
  assign sts_aadv_o = sts_q;
  assign ie_aadv_o  = ie_q;
endmodule

// File: rtl/usbh_irq_pacer.sv
module usbh_irq_pacer
  import usbh_opreg_pkg::*;
#(
  parameter int unsigned MAX_CODE = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [THR_W-1:0] code_i,
  input  logic             pend_i,
  output logic             irq_o
);
  localparam int unsigned CNT_W = (MAX_CODE > 0) ? MAX_CODE : 1;
  localparam logic [THR_W-1:0] MAX_C = THR_W'(MAX_CODE);
  localparam logic [CNT_W-1:0] ONES  = '1;

  logic [THR_W-1:0] code_eff;
  logic [CNT_W-1:0] lim, cnt_q;
  logic             bound, irq_q;
  int unsigned      sh;

  always_comb begin
    code_eff = (code_i > MAX_C) ? MAX_C : code_i;
    sh       = CNT_W - int'(code_eff);
    lim      = ONES >> sh;
  end

  // >= keeps a shrunk threshold from running the counter to wrap
  assign bound = tick_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (tick_i)
        cnt_q <= bound ? '0 : cnt_q + 1'b1;
      if (!pend_i)
        irq_q <= 1'b0;
      else if (bound)
        irq_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/usbh_opreg_top.sv
module usbh_opreg_top
  import usbh_opreg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned RST_CYCLES = 16,
  parameter int unsigned MAX_CODE   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              uframe_i,
  input  logic              evict_done_i,
  output logic              evict_req_o,
  output logic              async_en_o,
  output logic              periodic_en_o,
  output logic              hc_reset_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
  localparam logic [ADDR_W-1:0] A_IE  = ADDR_W'(OFS_IE);

  logic wr_cmd, wr_sts, wr_ie, start, busy, clr;
  logic sts_aadv, ie_aadv;
  logic unused_wdata;
  cmd_t cmd;

  assign wr_cmd = we_i && (addr_i == A_CMD);
  assign wr_sts = we_i && (addr_i == A_STS);
  assign wr_ie  = we_i && (addr_i == A_IE);
  assign start  = wr_cmd && wdata_i[CMD_HCRST] && !busy;
  assign unused_wdata = ^wdata_i;

  usbh_hcrst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .busy_o (busy),
    .clr_o  (clr)
  );

  usbh_opreg_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .wr_cmd_i    (wr_cmd),
    .wr_sts_i    (wr_sts),
    .wr_ie_i     (wr_ie),
    .w_per_i     (wdata_i[CMD_PER_EN]),
    .w_asy_i     (wdata_i[CMD_ASY_EN]),
    .w_dbell_i   (wdata_i[CMD_DBELL]),
    .w_thr_i     (wdata_i[CMD_THR_LO +: THR_W]),
    .w_aadv_i    (wdata_i[STS_AADV]),
    .evict_done_i(evict_done_i),
    .cmd_o       (cmd),
    .sts_aadv_o  (sts_aadv),
    .ie_aadv_o   (ie_aadv)
  );

  usbh_irq_pacer #(.MAX_CODE(MAX_CODE)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .tick_i(uframe_i),
    .code_i(cmd.thr),
    .pend_i(sts_aadv && ie_aadv),
    .irq_o (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CMD: begin
        rdata_o[CMD_HCRST]            = busy;
        rdata_o[CMD_FLS_LO +: 2]      = 2'b00;
        rdata_o[CMD_PER_EN]           = cmd.per_en;
        rdata_o[CMD_ASY_EN]           = cmd.asy_en;
        rdata_o[CMD_DBELL]            = cmd.dbell;
        rdata_o[CMD_THR_LO +: THR_W]  = cmd.thr;
      end
      A_STS: begin
        rdata_o[STS_AADV] = sts_aadv;
        rdata_o[STS_HALT] = busy;
      end
      A_IE:    rdata_o[IE_AADV] = ie_aadv;
      default: rdata_o = '0;
    endcase
  end

  assign evict_req_o   = cmd.dbell;
  assign async_en_o    = cmd.asy_en;
  assign periodic_en_o = cmd.per_en;
  assign hc_reset_o    = busy;
endmodule

// File: rtl/usbh_opreg_chk.sv
module usbh_opreg_chk #(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned RST_CYCLES = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              uframe_i,
  input logic              evict_done_i,
  input logic              evict_req_o,
  input logic              async_en_o,
  input logic              periodic_en_o,
  input logic              hc_reset_o,
  input logic              irq_o
);
  localparam int unsigned LEN_W = $clog2(RST_CYCLES + 1) + 1;

  logic [LEN_W-1:0] busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         busy_len <= '0;
    else if (hc_reset_o) busy_len <= busy_len + 1'b1;
    else                 busy_len <= '0;
  end

  AST_FLS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == '0) |-> (rdata_o[3:2] == 2'b00)); // R3
  AST_DB_NEEDS_ASYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evict_req_o) |-> async_en_o); // R5
  AST_DB_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evict_req_o && evict_done_i) |=> !evict_req_o); // R6
  AST_IRQ_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(uframe_i)); // R9
  AST_RST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hc_reset_o |-> (!irq_o && !async_en_o && !periodic_en_o && !evict_req_o)); // R11
  AST_RST_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hc_reset_o) |-> (busy_len == LEN_W'(RST_CYCLES))); // R11
endmodule

bind usbh_opreg_top usbh_opreg_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .RST_CYCLES(RST_CYCLES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .rdata_o      (rdata_o),
  .uframe_i     (uframe_i),
  .evict_done_i (evict_done_i),
  .evict_req_o  (evict_req_o),
  .async_en_o   (async_en_o),
  .periodic_en_o(periodic_en_o),
  .hc_reset_o   (hc_reset_o),
  .irq_o        (irq_o)
);

// File: tb/usbh_opreg_top_tb_top.sv
module usbh_opreg_top_tb_top;
  localparam int unsigned RSTC = 6;
  localparam int NV = 15;
  // {write, addr, data, expected read}
  localparam logic [68:0] VEC [NV] = '{
    {1'b0, 4'h0, 32'h0, 32'h0003_0000},   // R1
    {1'b0, 4'h4, 32'h0, 32'h0000_0000},   // R1
    {1'b0, 4'h8, 32'h0, 32'h0000_0000},   // R1
    {1'b1, 4'h0, 32'h0003_003C, 32'h0},   // R2 R3
    {1'b0, 4'h0, 32'h0, 32'h0003_0030},   // R2 R3
    {1'b1, 4'h0, 32'h0005_0010, 32'h0},   // R2
    {1'b0, 4'h0, 32'h0, 32'h0005_0010},   // R2
    {1'b1, 4'h0, 32'h0005_0040, 32'h0},   // R5
    {1'b0, 4'h0, 32'h0, 32'h0005_0000},   // R5
    {1'b1, 4'h0, 32'h0005_0060, 32'h0},   // R4
    {1'b0, 4'h0, 32'h0, 32'h0005_0060},   // R4
    {1'b1, 4'h0, 32'h0005_0020, 32'h0},   // R4
    {1'b0, 4'h0, 32'h0, 32'h0005_0060},   // R4
    {1'b1, 4'h8, 32'h0000_0020, 32'h0},   // R9 setup
    {1'b0, 4'h8, 32'h0, 32'h0000_0020}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        uframe_i = 1'b0;
  logic        evict_done_i = 1'b0;
  logic        evict_req_o, async_en_o, periodic_en_o, hc_reset_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  int busy_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  usbh_opreg_top #(.ADDR_W(4), .DATA_W(32), .RST_CYCLES(RSTC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .uframe_i(uframe_i),
    .evict_done_i(evict_done_i), .evict_req_o(evict_req_o),
    .async_en_o(async_en_o), .periodic_en_o(periodic_en_o),
    .hc_reset_o(hc_reset_o), .irq_o(irq_o)
  );

  always @(negedge clk) if (hc_reset_o) busy_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic rdchk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic evict_pulse();
    @(negedge clk); evict_done_i = 1'b1;
    @(negedge clk); evict_done_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); uframe_i = 1'b1;
      @(negedge clk); uframe_i = 1'b0;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 outputs", {27'd0, irq_o, evict_req_o, hc_reset_o, async_en_o, periodic_en_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][68]) wr(VEC[i][67:64], VEC[i][63:32]);
      else rdchk($sformatf("table vec %0d (R1-R5 group)", i), VEC[i][67:64], VEC[i][31:0]);
    end

    chk("R4 evict_req_o", {31'd0, evict_req_o}, 32'd1);
    chk("R2 enables", {30'd0, async_en_o, periodic_en_o}, 32'd2);

    evict_pulse();
    rdchk("R6 doorbell cleared", 4'h0, 32'h0005_0020);
    rdchk("R6 status set", 4'h4, 32'h0000_0020);
    chk("R9 no irq before boundary", {31'd0, irq_o}, 32'd0);

    wr(4'h0, 32'h0002_0020);
    ticks(3);
    chk("R8 period 4, 3 strobes", {31'd0, irq_o}, 32'd0);
    ticks(1);
    chk("R9 irq at boundary", {31'd0, irq_o}, 32'd1);

    wr(4'h4, 32'h0);
    rdchk("R7 write 0 keeps status", 4'h4, 32'h0000_0020);
    wr(4'h4, 32'h0000_0020);
    rdchk("R7 w1c clears", 4'h4, 32'h0);
    @(negedge clk);
    chk("R10 irq drops after clear", {31'd0, irq_o}, 32'd0);

    wr(4'h0, 32'h0007_0060);
    evict_pulse();
    ticks(63);
    chk("R8 code 7, 63 strobes", {31'd0, irq_o}, 32'd0);
    ticks(1);
    chk("R8 code 7, 64th strobe", {31'd0, irq_o}, 32'd1);
    wr(4'h8, 32'h0);
    @(negedge clk);
    chk("R10 irq drops on enable clear", {31'd0, irq_o}, 32'd0);

    wr(4'h0, 32'h0007_0060);
    @(negedge clk);
    we_i = 1'b1; addr_i = 4'h4; wdata_i = 32'h0000_0020; evict_done_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0; evict_done_i = 1'b0;
    rdchk("R7 set wins over clear", 4'h4, 32'h0000_0020);

    wr(4'h4, 32'h0000_0020);
    evict_pulse();
    rdchk("R6 done without doorbell", 4'h4, 32'h0);

    wr(4'h0, 32'h0002_0020);
    ticks(2);

    b0 = busy_cnt;
    wr(4'h0, 32'h0002_0032);
    chk("R11 hc_reset_o", {31'd0, hc_reset_o}, 32'd1);
    rdchk("R11 cmd during reset", 4'h0, 32'h0003_0002);
    rdchk("R11 halted", 4'h4, 32'h0000_1000);
    chk("R11 enables low", {30'd0, async_en_o, periodic_en_o}, 32'd0);
    wr(4'h0, 32'h0);
    chk("R11 cannot cancel", {31'd0, hc_reset_o}, 32'd1);
    wr(4'h8, 32'h0000_0020);
    while (hc_reset_o) @(negedge clk);
    chk("R11 reset length", busy_cnt - b0, RSTC);

    rdchk("R12 cmd default", 4'h0, 32'h0003_0000);
    rdchk("R12 sts default", 4'h4, 32'h0);
    rdchk("R12 ie default", 4'h8, 32'h0);

    wr(4'h8, 32'h0000_0020);
    wr(4'h0, 32'h0003_0060);
    evict_pulse();
    ticks(7);
    chk("R12 counter restarted, 7 strobes", {31'd0, irq_o}, 32'd0);
    ticks(1);
    chk("R12 counter restarted, 8th strobe", {31'd0, irq_o}, 32'd1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule